// File: doc/BRIEF.md
# Protection Fault Counter and Restart Logic

This block collects the protection events of a switching power controller and decides when the power stage must stop. Its inputs are five flags. Two come from per-cycle current-sense comparators: over-current and short-circuit. The other three are a fault-pin over-voltage flag, a thermal flag and a supply-reset flag. A level input `gate_on` follows the main switch, and its rising edge marks each turn-on.

The current-sense flags are blanked for a set number of clock cycles after each turn-on. A flag that survives blanking marks that switching cycle as an event cycle. Over-current and short-circuit event cycles are counted in separate counters, each with its own limit, and only unbroken runs of event cycles count. The over-voltage flag must persist for a qualification delay before it is accepted. The thermal flag acts at once.

When a fault is declared, the block raises `drv_inhibit` and reports a fault code. The configuration decides, per fault class, what happens next:
- **Latched:** the inhibit holds until the supply-reset flag arrives.
- **Auto-restart:** a long restart timer runs, after which the inhibit drops and a one-cycle restart request is issued.

All time quantities are counts of the block clock.

Top module: `prot_fault_sup`

## Requirements
- R1: An over-current comparator level is ignored in the first OC_BLANK clock cycles of each on-time. The on-time is the span with `gate_on` high, and the first high sample is index 0. A level at index OC_BLANK or later qualifies the cycle. OC_BLANK is 23 by default and 14 when FAST_BLANK is set.
- R2: The short-circuit comparator is blanked the same way for SC_BLANK cycles, 17 by default and 8 when FAST_BLANK is set.
- R3: A short-circuit fault is declared at the turn-off of the 5th consecutive switching cycle that contains a qualified short-circuit event. A completed cycle without such an event restarts the run from zero.
- R4: An over-current fault is declared at the turn-off of the `oc_limit`-th consecutive cycle that contains a qualified over-current event (`oc_limit` ≥ 1). The run restarts from zero in the same way as in R3.
- R5: `ov_flag` is accepted as a fault on the clock edge of its OV_DELAY-th consecutive high sample (35 by default). A shorter run of high samples has no effect.
- R6: A high `ot_flag` sample declares a thermal fault on that same clock edge.
- R7: `fault_code` reads 0 when there is no fault, 1 for over-current, 2 for short-circuit, 3 for over-voltage and 4 for thermal. When faults trip together, the code follows the priority thermal > over-voltage > short-circuit > over-current.
- R8: `latch_cfg` bit 0 sets the policy for over-current, bit 1 for short-circuit, bit 2 for over-voltage and bit 3 for thermal. A bit value of 1 means latched and 0 means auto-restart.
- R9: An auto-restart fault keeps `drv_inhibit` high for RESTART_CYC cycles after the declaring edge (1600 by default). Then `drv_inhibit` and `fault_code` return to 0, and `restart_req` is high for exactly one cycle.
- R10: A latched fault holds until `vcc_reset` is sampled high. The fault clears on that edge, with no restart request. `vcc_reset` also cancels an auto-restart wait and takes precedence over any trip.
- R11: During and right after reset, `drv_inhibit`, `fault_code` and `restart_req` are all 0.
- R12: While `drv_inhibit` is high, new trips of any kind are ignored and `fault_code` keeps the first fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_on | input | 1 | High while the main switch is on |
| oc_cmp | input | 1 | Over-current comparator output |
| sc_cmp | input | 1 | Short-circuit comparator output |
| ov_flag | input | 1 | Fault-pin over-voltage comparator output |
| ot_flag | input | 1 | Thermal sensor flag |
| vcc_reset | input | 1 | Supply has fallen below the reset level |
| latch_cfg | input | 4 | Per-class latched (1) or auto-restart (0) policy |
| oc_limit | input | CNT_W | Consecutive over-current cycles needed for a fault |
| drv_inhibit | output | 1 | Forces the power stage off |
| fault_code | output | 3 | Code of the active fault |
| restart_req | output | 1 | One-cycle pulse when an auto-restart wait ends |

## Verification
Some properties are checked by the assertions on every cycle:
- No current-sense event qualifies on the turn-on sample.
- A run counter never reaches its limit.
- A low over-voltage sample blocks a trip on the next edge.
- Any trip taken while running raises the inhibit on the following cycle, and a thermal trip reports code 4.
- A supply reset always clears the fault.
- A held fault keeps its code.
- The restart request is a single pulse outside inhibit.

Other behaviours can only be shown by the bench's scenarios:
- The exact blanking boundaries of R1 and R2.
- The consecutive-cycle counting and its reset on a clean cycle.
- The precise OV_DELAY qualification and the full restart window length.
- Priority among faults that trip together.
- The per-class latch policy.

// File: rtl/prot_pkg.sv
package prot_pkg;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_OC   = 3'd1,
    FLT_SC   = 3'd2,
    FLT_OV   = 3'd3,
    FLT_OT   = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    SEQ_RUN   = 2'd0,
    SEQ_RETRY = 2'd1,
    SEQ_HOLD  = 2'd2
  } seq_e;

  // trip vector bit order: 3 thermal, 2 over-voltage, 1 short-circuit, 0 over-current
  function automatic fault_e pick_fault(input logic [3:0] trips);
    if (trips[3])      return FLT_OT;
    else if (trips[2]) return FLT_OV;
    else if (trips[1]) return FLT_SC;
    else if (trips[0]) return FLT_OC;
    else               return FLT_NONE;
  endfunction

  function automatic logic class_latched(input fault_e f, input logic [3:0] cfg);
    case (f)
      FLT_OC:  return cfg[0];
      FLT_SC:  return cfg[1];
      FLT_OV:  return cfg[2];
      FLT_OT:  return cfg[3];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cs_event_counter.sv
module cs_event_counter #(
  parameter int BLANK_CYC = 23,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             gate_on,
  input  logic             cmp,
  input  logic [CNT_W-1:0] limit,
  output logic             trip
);
  localparam int BW = $clog2(BLANK_CYC + 2);

  logic [BW-1:0]    blank_cnt;
  logic             gate_d;
  logic             seen;
  logic [CNT_W-1:0] run_cnt;

  // named internal events
  logic             blank_done;
  logic             evt_qual;
  logic             cyc_end;
  logic [CNT_W-1:0] eff_lim;

  assign blank_done = (blank_cnt == BW'(BLANK_CYC));
  assign evt_qual   = gate_on & cmp & blank_done & ~clr;
  assign cyc_end    = gate_d & ~gate_on;
  assign eff_lim    = (limit == '0) ? CNT_W'(1) : limit;
  assign trip       = cyc_end & seen & ~clr & (run_cnt == eff_lim - CNT_W'(1));

  // blanking window measured from each turn-on
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_cnt <= '0;
      gate_d    <= 1'b0;
    end else begin
      gate_d <= gate_on;
      if (!gate_on)        blank_cnt <= '0;
      else if (!blank_done) blank_cnt <= blank_cnt + BW'(1);
    end
  end

  // one count step per switching cycle, run broken by a clean cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      run_cnt <= '0;
    end else if (clr) begin
      seen    <= 1'b0;
      run_cnt <= '0;
    end else if (cyc_end) begin
      seen <= 1'b0;
      if (seen && !trip) run_cnt <= run_cnt + CNT_W'(1);
      else               run_cnt <= '0;
    end else if (evt_qual) begin
      seen <= 1'b1;
    end
  end

  if (BLANK_CYC > 0) begin : g_blank_chk
    // R1 (R2 on the short-circuit channel): turn-on sample never qualifies
    assert_blank_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_on) |-> !evt_qual);
  end

  // R4 (R3 on the short-circuit channel): the run stays below its limit
  assert_run_below_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt < eff_lim);

endmodule

// File: rtl/ov_persist.sv
module ov_persist #(
  parameter int DELAY = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ov_flag,
  output logic ov_trip
);
  localparam int OW = $clog2(DELAY + 1);

  logic [OW-1:0] hi_cnt;

  assign ov_trip = ov_flag & ~clr & (hi_cnt == OW'(DELAY - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_cnt <= '0;
    else if (clr || !ov_flag)  hi_cnt <= '0;
    else if (!ov_trip)         hi_cnt <= hi_cnt + OW'(1);
  end

  if (DELAY > 1) begin : g_ov_chk
    // R5: a low sample forbids acceptance on the next edge
    assert_ov_needs_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ov_flag |=> !ov_trip);
  end

endmodule

// File: rtl/fault_sequencer.sv
module fault_sequencer
  import prot_pkg::*;
#(
  parameter int RESTART_CYC = 1600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_reset,
  input  logic [3:0] trips,
  input  logic [3:0] latch_cfg,
  output logic       drv_inhibit,
  output logic [2:0] fault_code,
  output logic       restart_req
);
  localparam int TW = $clog2(RESTART_CYC + 1);

  seq_e          state;
  fault_e        code_q;
  logic [TW-1:0] timer;

  // named internal events
  fault_e        new_fault;
  logic          any_trip;
  logic          timer_done;

  assign new_fault   = pick_fault(trips);
  assign any_trip    = |trips;
  assign timer_done  = (timer == TW'(RESTART_CYC - 1));
  assign drv_inhibit = (state != SEQ_RUN);
  assign fault_code  = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SEQ_RUN;
      code_q      <= FLT_NONE;
      timer       <= '0;
      restart_req <= 1'b0;
    end else begin
      restart_req <= 1'b0;
      if (vcc_reset) begin
        state  <= SEQ_RUN;
        code_q <= FLT_NONE;
        timer  <= '0;
      end else begin
        case (state)
          SEQ_RUN: if (any_trip) begin
            code_q <= new_fault;
            timer  <= '0;
            state  <= class_latched(new_fault, latch_cfg) ? SEQ_HOLD : SEQ_RETRY;
          end
          SEQ_RETRY: if (timer_done) begin
            state       <= SEQ_RUN;
            code_q      <= FLT_NONE;
            restart_req <= 1'b1;
          end else begin
            timer <= timer + TW'(1);
          end
          default: ;
        endcase
      end
    end
  end

  assert_trip_inhibits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_RUN && any_trip && !vcc_reset) |=> drv_inhibit);

  assert_thermal_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_RUN && trips[3] && !vcc_reset) |=> fault_code == FLT_OT);

  assert_code_tracks_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drv_inhibit == (fault_code != FLT_NONE));

  assert_restart_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req);

  assert_restart_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> !drv_inhibit);

  assert_supply_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_reset |=> (!drv_inhibit && fault_code == FLT_NONE));

  assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_HOLD && !vcc_reset) |=> (drv_inhibit && $stable(fault_code)));

endmodule

// File: rtl/prot_fault_sup.sv
module prot_fault_sup #(
  parameter bit FAST_BLANK    = 1'b0,
  parameter int OC_BLANK_STD  = 23,
  parameter int OC_BLANK_FAST = 14,
  parameter int SC_BLANK_STD  = 17,
  parameter int SC_BLANK_FAST = 8,
  parameter int SC_LIMIT      = 5,
  parameter int CNT_W         = 4,
  parameter int OV_DELAY      = 35,
  parameter int RESTART_CYC   = 1600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_on,
  input  logic             oc_cmp,
  input  logic             sc_cmp,
  input  logic             ov_flag,
  input  logic             ot_flag,
  input  logic             vcc_reset,
  input  logic [3:0]       latch_cfg,
  input  logic [CNT_W-1:0] oc_limit,
  output logic             drv_inhibit,
  output logic [2:0]       fault_code,
  output logic             restart_req
);
  localparam int OC_BLANK = FAST_BLANK ? OC_BLANK_FAST : OC_BLANK_STD;
  localparam int SC_BLANK = FAST_BLANK ? SC_BLANK_FAST : SC_BLANK_STD;

  logic       clr_all;
  logic [1:0] cmp_vec;
  logic [1:0] ch_trip;
  logic       ov_trip;
  logic [3:0] trips;

  assign clr_all = drv_inhibit | vcc_reset;
  assign cmp_vec = {sc_cmp, oc_cmp};

  // channel 0 over-current, channel 1 short-circuit
  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    localparam int BLK = (ch == 0) ? OC_BLANK : SC_BLANK;
    logic [CNT_W-1:0] lim;
    assign lim = (ch == 0) ? oc_limit : CNT_W'(SC_LIMIT);

    cs_event_counter #(
      .BLANK_CYC(BLK),
      .CNT_W    (CNT_W)
    ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_all),
      .gate_on(gate_on),
      .cmp    (cmp_vec[ch]),
      .limit  (lim),
      .trip   (ch_trip[ch])
    );
  end

  ov_persist #(
    .DELAY(OV_DELAY)
  ) u_ov (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_all),
    .ov_flag(ov_flag),
    .ov_trip(ov_trip)
  );

  assign trips = {ot_flag, ov_trip, ch_trip[1], ch_trip[0]};

  fault_sequencer #(
    .RESTART_CYC(RESTART_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .vcc_reset  (vcc_reset),
    .trips      (trips),
    .latch_cfg  (latch_cfg),
    .drv_inhibit(drv_inhibit),
    .fault_code (fault_code),
    .restart_req(restart_req)
  );

endmodule

// File: tb/prot_fault_sup_tb.sv
module prot_fault_sup_tb;
  localparam int OCB = 23;
  localparam int SCB = 17;
  localparam int OVD = 35;
  localparam int RC  = 1600;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       gate_on, oc_cmp, sc_cmp, ov_flag, ot_flag, vcc_reset;
  logic [3:0] latch_cfg;
  logic [3:0] oc_limit;
  logic       drv_inhibit, restart_req;
  logic [2:0] fault_code;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  prot_fault_sup u_dut (
    .clk(clk), .rst_n(rst_n), .gate_on(gate_on), .oc_cmp(oc_cmp), .sc_cmp(sc_cmp),
    .ov_flag(ov_flag), .ot_flag(ot_flag), .vcc_reset(vcc_reset), .latch_cfg(latch_cfg),
    .oc_limit(oc_limit), .drv_inhibit(drv_inhibit), .fault_code(fault_code),
    .restart_req(restart_req)
  );

  // reference priority: thermal, over-voltage, short-circuit, over-current
  function automatic int exp_code(bit ot, bit ov, bit sc, bit oc);
    int c;
    c = 0;
    if (oc) c = 1;
    if (sc) c = 2;
    if (ov) c = 3;
    if (ot) c = 4;
    return c;
  endfunction

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // one switching cycle: comparators high for on-index from <= k < to
  task automatic run_cycle(int on_len, int oc_from, int oc_to, int sc_from, int sc_to);
    for (int k = 0; k < on_len; k++) begin
      gate_on = 1'b1;
      oc_cmp  = (k >= oc_from) && (k < oc_to);
      sc_cmp  = (k >= sc_from) && (k < sc_to);
      tick();
    end
    gate_on = 1'b0; oc_cmp = 1'b0; sc_cmp = 1'b0;
    tick(2);
  endtask

  task automatic supply_clear();
    vcc_reset = 1'b1;
    tick();
    vcc_reset = 1'b0;
    tick();
  endtask

  initial begin : watchdog
    #(10 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    int oc_run, sc_run, lim, ec, on_len;
    bit oc_ev, sc_ev;
    rst_n = 1'b0; gate_on = 0; oc_cmp = 0; sc_cmp = 0; ov_flag = 0; ot_flag = 0;
    vcc_reset = 0; latch_cfg = 4'hF; oc_limit = 4'd3;
    tick(3);
    check("R11 inhibit in reset", drv_inhibit, 0);
    check("R11 code in reset", fault_code, 0);
    rst_n = 1'b1;
    tick();
    check("R11 restart after reset", restart_req, 0);

    // R1: levels confined to the blanking window never count
    for (int i = 0; i < 4; i++) run_cycle(OCB, 0, OCB, 99, 99);
    check("R1 blanked over-current", fault_code, 0);
    // R4: three consecutive qualified cycles with oc_limit = 3
    run_cycle(OCB + 1, OCB, OCB + 1, 99, 99);
    run_cycle(OCB + 5, OCB, OCB + 5, 99, 99);
    check("R4 below limit", drv_inhibit, 0);
    run_cycle(OCB + 5, OCB, OCB + 5, 99, 99);
    check("R4 over-current code", fault_code, 1);
    check("R4 inhibit", drv_inhibit, 1);
    // R8 latched hold, R12 later thermal ignored
    tick(50);
    check("R8 latched hold", fault_code, 1);
    ot_flag = 1'b1; tick(2); ot_flag = 1'b0; tick();
    check("R12 first fault kept", fault_code, 1);
    vcc_reset = 1'b1; tick();
    check("R10 supply clear code", fault_code, 0);
    check("R10 supply clear inhibit", drv_inhibit, 0);
    check("R10 no restart on latched clear", restart_req, 0);
    vcc_reset = 1'b0; tick();

    // R2 short-circuit blanking, R3 consecutive counting
    for (int i = 0; i < 6; i++) run_cycle(SCB, 99, 99, 0, SCB);
    check("R2 blanked short-circuit", fault_code, 0);
    for (int i = 0; i < 4; i++) run_cycle(SCB + 3, 99, 99, SCB, SCB + 3);
    run_cycle(SCB + 3, 99, 99, 99, 99);
    for (int i = 0; i < 4; i++) run_cycle(SCB + 3, 99, 99, SCB, SCB + 3);
    check("R3 broken run", fault_code, 0);
    run_cycle(SCB + 3, 99, 99, SCB, SCB + 3);
    check("R3 short-circuit code", fault_code, 2);
    supply_clear();

    // R7 short-circuit beats over-current in the same cycle
    oc_limit = 4'd5;
    for (int i = 0; i < 5; i++) run_cycle(OCB + 4, OCB, OCB + 4, SCB, OCB + 4);
    check("R7 sc over oc", fault_code, exp_code(0, 0, 1, 1));
    supply_clear();

    // R5 over-voltage persistence
    ov_flag = 1'b1; tick(OVD - 1); ov_flag = 1'b0; tick();
    check("R5 short pulse", fault_code, 0);
    ov_flag = 1'b1; tick(OVD - 1);
    check("R5 one short of delay", fault_code, 0);
    tick();
    check("R5 over-voltage code", fault_code, 3);
    ov_flag = 1'b0;
    supply_clear();

    // R7 thermal beats over-voltage on the same edge
    ov_flag = 1'b1; tick(OVD - 1); ot_flag = 1'b1; tick();
    check("R7 ot over ov", fault_code, exp_code(1, 1, 0, 0));
    ov_flag = 1'b0; ot_flag = 1'b0;
    supply_clear();

    // R6 immediate thermal, R9 auto-restart window
    latch_cfg = 4'h0;
    ot_flag = 1'b1; tick(); ot_flag = 1'b0;
    check("R6 thermal immediate", fault_code, 4);
    tick(RC - 1);
    check("R9 still inhibited", drv_inhibit, 1);
    check("R9 no early restart", restart_req, 0);
    tick();
    check("R9 released", drv_inhibit, 0);
    check("R9 restart pulse", restart_req, 1);
    check("R9 code cleared", fault_code, 0);
    tick();
    check("R9 pulse ends", restart_req, 0);

    // R8 per-class bit: short-circuit latched, others auto
    latch_cfg = 4'b0010;
    for (int i = 0; i < 5; i++) run_cycle(SCB + 2, 99, 99, SCB, SCB + 2);
    tick(RC + 10);
    check("R8 sc bit latched", fault_code, 2);
    // R10 supply reset cancels an auto-restart wait
    supply_clear();
    oc_limit = 4'd1;
    run_cycle(OCB + 2, OCB, OCB + 2, 99, 99);
    check("R8 oc auto code", fault_code, 1);
    vcc_reset = 1'b1; tick();
    check("R10 cancel wait", drv_inhibit, 0);
    check("R10 cancel no restart", restart_req, 0);
    vcc_reset = 1'b0; tick();

    // random mix, all classes latched
    latch_cfg = 4'hF;
    void'($urandom(32'h5EED));
    oc_run = 0; sc_run = 0;
    lim = 1 + int'($urandom % 6);
    oc_limit = 4'(lim);
    for (int n = 0; n < 300; n++) begin
      on_len = 24 + int'($urandom % 10);
      oc_ev  = ($urandom % 4) != 0;
      sc_ev  = ($urandom % 3) == 0;
      run_cycle(on_len,
                oc_ev ? OCB + int'($urandom % (on_len - OCB)) : int'($urandom % OCB),
                oc_ev ? on_len : OCB,
                sc_ev ? SCB + int'($urandom % (on_len - SCB)) : int'($urandom % SCB),
                sc_ev ? on_len : SCB);
      oc_run = oc_ev ? oc_run + 1 : 0;
      sc_run = sc_ev ? sc_run + 1 : 0;
      ec = exp_code(0, 0, sc_run >= 5, oc_run >= lim);
      check("R4 R3 random cycle", fault_code, ec);
      if (ec != 0) begin
        supply_clear();
        oc_run = 0; sc_run = 0;
        lim = 1 + int'($urandom % 6);
        oc_limit = 4'(lim);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule